// File: doc/BRIEF.md
# In-Order Completion Queue

This block keeps track of instructions between dispatch and retirement. It is a circular reorder queue of fourteen slots. Each dispatched instruction gets a slot in program order, and the slot index is its tag. Execution units report finished work by tag, in any order. The queue retires the oldest finished entries, at most two per clock, and always in program order.

Two things can change the instruction flow. The first is internal: an entry that carries an exception or a refetch mark retires on its own when it reaches the head. In that same cycle it raises a flush that discards every younger entry. The second is external: a redirect request names a tag. Entries up to and including that tag are kept, and the younger ones are dropped. An entry marked for serialization at completion must wait until it is the oldest entry. The block tells the execution side, through a go signal, when that entry may run.

Top module: `cmpl_queue`

## Requirements
- R1: The queue holds at most 14 entries. A dispatch request stalls (`disp_stall`=1) when the number of free slots is smaller than the number of lanes requested. The free count uses the occupancy at the start of the cycle, so a slot freed by retirement in that cycle is not yet counted. Otherwise the request is accepted.
- R2: Dispatch lane 0 gets the tag at the tail. Lane 1 gets the next tag if lane 0 also requests, and the tail tag if it does not. Tags are slot indices 0 to 13 and wrap from 13 to 0.
- R3: A finish report sets the finished state of a valid slot. A report that names a slot that is not valid has no effect: an instruction allocated to that slot later does not retire until its own report arrives.
- R4: Retirement follows program order. An entry retires only when it is at the head and finished. A finished younger entry never retires ahead of an unfinished older one.
- R5: Two entries retire in one cycle (`ret_vld`=2'b11, tags head and head+1) only when both are finished and neither carries an exception or a refetch mark. Lane 1 never retires without lane 0.
- R6: An exception (reported with the finish) or a refetch mark (given at dispatch) on the head entry makes that entry retire alone, with `flush_out`=1 in the same cycle. All younger entries are discarded, including finished ones. The next dispatch then receives the tag just after the flushing entry.
- R7: A redirect naming a valid tag keeps the entries from the head through that tag and discards the younger ones. In that cycle it blocks retirement and stalls dispatch. The next dispatch receives the tag after the named one. A redirect naming an invalid slot has no effect.
- R8: `ser_go` is 1 exactly when the head entry is valid, unfinished and marked for serialization. A serialized entry that is not at the head gives `ser_go`=0.
- R9: After reset the queue is empty, with no retirement, no flush and `ser_go`=0, and the first dispatch pair receives tags 0 and 1.
- R10: A dispatch request made in a cycle where `flush_out` is 1 stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_req | input | 2 | Dispatch request per lane |
| disp_ser | input | 2 | Serialize-at-completion mark per lane |
| disp_rfch | input | 2 | Refetch-after-retire mark per lane |
| disp_stall | output | 1 | Dispatch request refused this cycle |
| disp_tag0 | output | 4 | Tag given to lane 0 |
| disp_tag1 | output | 4 | Tag given to lane 1 |
| fin_vld | input | 2 | Finish report valid per port |
| fin_tag | input | 8 | Finish tags, port p in bits [4p+3:4p] |
| fin_exc | input | 2 | Finish report carries an exception |
| redir_vld | input | 1 | External redirect request |
| redir_tag | input | 4 | Youngest tag kept by the redirect |
| ret_vld | output | 2 | Retire lanes active this cycle |
| ret_tag0 | output | 4 | Tag retiring on lane 0 |
| ret_tag1 | output | 4 | Tag retiring on lane 1 |
| flush_out | output | 1 | Head retires with a flush of all younger entries |
| ser_go | output | 1 | Serialized head entry may execute |

## Verification
Dispatch tags and `disp_stall` are combinational on the request, so they are checked in the cycle the request is driven. A finish report takes effect at the next clock edge, so the retirement it enables shows on `ret_vld`, `ret_tag*` and `flush_out` one cycle after the report. That retirement commits at the edge after that. The effect of a flush or redirect on the tail shows up as the tag offered to the next cycle's dispatch. Inputs change on the falling edge and outputs are sampled 5 ns before the rising edge. Expected retirements are queued when the finish report is driven, and a monitor pops them exactly in the cycle they fall due.

// File: rtl/cq_pkg.sv
`timescale 1ns/1ps
package cq_pkg;

  // modular reduction for values below twice the queue depth
  function automatic int cq_wrap(input int v, input int depth);
    return (v >= depth) ? v - depth : v;
  endfunction

endpackage

// File: rtl/cq_entries.sv
`timescale 1ns/1ps
module cq_entries #(
  parameter int DEPTH = 14,
  parameter int NFIN  = 2,
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DEPTH-1:0]     alloc_en,
  input  logic [DEPTH-1:0]     alloc_ser,
  input  logic [DEPTH-1:0]     alloc_rf,
  input  logic [DEPTH-1:0]     kill,
  input  logic [NFIN-1:0]      fin_vld,
  input  logic [NFIN*TW-1:0]   fin_tag,
  input  logic [NFIN-1:0]      fin_exc,
  output logic [DEPTH-1:0]     slot_vld,
  output logic [DEPTH-1:0]     slot_done,
  output logic [DEPTH-1:0]     slot_exc,
  output logic [DEPTH-1:0]     slot_ser,
  output logic [DEPTH-1:0]     slot_rf
);

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic hit, hit_exc, en;
    logic v_q, d_q, e_q, s_q, r_q;
    logic v_d, d_d, e_d, s_d, r_d;

    always_comb begin
      hit     = 1'b0;
      hit_exc = 1'b0;
      for (int p = 0; p < NFIN; p++) begin
        if (fin_vld[p] && fin_tag[p*TW +: TW] == TW'(s)) begin
          hit     = 1'b1;
          hit_exc = hit_exc | fin_exc[p];
        end
      end
    end

    always_comb begin
      v_d = v_q;
      d_d = d_q;
      e_d = e_q;
      s_d = s_q;
      r_d = r_q;
      en  = 1'b0;
      if (alloc_en[s]) begin
        en  = 1'b1;
        v_d = 1'b1;
        d_d = 1'b0;
        e_d = 1'b0;
        s_d = alloc_ser[s];
        r_d = alloc_rf[s];
      end else if (kill[s]) begin
        en  = 1'b1;
        v_d = 1'b0;
        d_d = 1'b0;
        e_d = 1'b0;
      end else if (v_q && hit) begin
        en  = 1'b1;
        d_d = 1'b1;
        e_d = e_q | hit_exc;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        e_q <= 1'b0;
        s_q <= 1'b0;
        r_q <= 1'b0;
      end else if (en) begin
        v_q <= v_d;
        d_q <= d_d;
        e_q <= e_d;
        s_q <= s_d;
        r_q <= r_d;
      end
    end

    assign slot_vld[s]  = v_q;
    assign slot_done[s] = d_q;
    assign slot_exc[s]  = e_q;
    assign slot_ser[s]  = s_q;
    assign slot_rf[s]   = r_q;

    // a report aimed at an empty slot must not mark it finished
    assert_ghost_finish_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!v_q && !alloc_en[s]) |=> !d_q);
  end

endmodule

// File: rtl/cq_dispatch.sv
`timescale 1ns/1ps
module cq_dispatch
  import cq_pkg::*;
#(
  parameter int DEPTH = 14,
  localparam int TW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [TW-1:0]    tl,
  input  logic [CW-1:0]    cnt,
  input  logic             hold,
  input  logic [1:0]       req,
  input  logic [1:0]       ser,
  input  logic [1:0]       rf,
  output logic             stall,
  output logic [TW-1:0]    tag0,
  output logic [TW-1:0]    tag1,
  output logic [DEPTH-1:0] alloc_en,
  output logic [DEPTH-1:0] alloc_ser,
  output logic [DEPTH-1:0] alloc_rf,
  output logic [1:0]       n_acc
);

  logic [1:0]    n_req;
  logic [CW-1:0] free;
  logic          go0, go1;

  always_comb begin
    n_req = {1'b0, req[0]} + {1'b0, req[1]};
    free  = CW'(DEPTH) - cnt;
    stall = (|req) && (hold || (CW'(n_req) > free));
    tag0  = tl;
    tag1  = TW'(cq_wrap(int'(tl) + int'(req[0]), DEPTH));
    go0   = req[0] && !stall;
    go1   = req[1] && !stall;
    n_acc = stall ? 2'd0 : n_req;
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_alloc
    logic hit0, hit1;
    always_comb begin
      hit0         = go0 && (tag0 == TW'(s));
      hit1         = go1 && (tag1 == TW'(s));
      alloc_en[s]  = hit0 || hit1;
      alloc_ser[s] = hit0 ? ser[0] : ser[1];
      alloc_rf[s]  = hit0 ? rf[0]  : rf[1];
    end
  end

endmodule

// File: rtl/cq_retire.sv
`timescale 1ns/1ps
module cq_retire
  import cq_pkg::*;
#(
  parameter int DEPTH = 14,
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic [TW-1:0]    hd,
  input  logic             block,
  input  logic [DEPTH-1:0] vld,
  input  logic [DEPTH-1:0] done,
  input  logic [DEPTH-1:0] exc,
  input  logic [DEPTH-1:0] rf,
  input  logic [DEPTH-1:0] ser,
  output logic [1:0]       ret_vld,
  output logic [TW-1:0]    tag0,
  output logic [TW-1:0]    tag1,
  output logic             flush,
  output logic             ser_go
);

  logic [TW-1:0] h1;
  logic          head_ok, solo, next_ok;

  always_comb begin
    h1         = TW'(cq_wrap(int'(hd) + 1, DEPTH));
    head_ok    = vld[hd] && done[hd] && !block;
    solo       = exc[hd] || rf[hd];
    next_ok    = vld[h1] && done[h1] && !exc[h1] && !rf[h1];
    ret_vld[0] = head_ok;
    ret_vld[1] = head_ok && !solo && next_ok;
    flush      = head_ok && solo;
    ser_go     = vld[hd] && ser[hd] && !done[hd];
    tag0       = hd;
    tag1       = h1;
  end

endmodule

// File: rtl/cmpl_queue.sv
`timescale 1ns/1ps
module cmpl_queue
  import cq_pkg::*;
#(
  parameter int DEPTH = 14,
  parameter int NFIN  = 2,
  localparam int TW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         disp_req,
  input  logic [1:0]         disp_ser,
  input  logic [1:0]         disp_rfch,
  output logic               disp_stall,
  output logic [TW-1:0]      disp_tag0,
  output logic [TW-1:0]      disp_tag1,
  input  logic [NFIN-1:0]    fin_vld,
  input  logic [NFIN*TW-1:0] fin_tag,
  input  logic [NFIN-1:0]    fin_exc,
  input  logic               redir_vld,
  input  logic [TW-1:0]      redir_tag,
  output logic [1:0]         ret_vld,
  output logic [TW-1:0]      ret_tag0,
  output logic [TW-1:0]      ret_tag1,
  output logic               flush_out,
  output logic               ser_go
);

  logic [TW-1:0]    hd_q, hd_d, tl_q, tl_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             ptr_en;
  logic [DEPTH-1:0] slot_vld, slot_done, slot_exc, slot_ser, slot_rf;
  logic [DEPTH-1:0] alloc_en, alloc_ser, alloc_rf, kill;
  logic [1:0]       n_acc, n_ret;
  logic             redir_hit;
  int               tag_off;

  // an external redirect counts only when it names a live slot
  always_comb begin
    redir_hit = redir_vld && (int'(redir_tag) < DEPTH) && slot_vld[redir_tag];
    tag_off   = cq_wrap(int'(redir_tag) + DEPTH - int'(hd_q), DEPTH);
  end

  cq_dispatch #(.DEPTH(DEPTH)) u_disp (
    .tl        (tl_q),
    .cnt       (cnt_q),
    .hold      (flush_out || redir_hit),
    .req       (disp_req),
    .ser       (disp_ser),
    .rf        (disp_rfch),
    .stall     (disp_stall),
    .tag0      (disp_tag0),
    .tag1      (disp_tag1),
    .alloc_en  (alloc_en),
    .alloc_ser (alloc_ser),
    .alloc_rf  (alloc_rf),
    .n_acc     (n_acc)
  );

  cq_retire #(.DEPTH(DEPTH)) u_ret (
    .hd      (hd_q),
    .block   (redir_hit),
    .vld     (slot_vld),
    .done    (slot_done),
    .exc     (slot_exc),
    .rf      (slot_rf),
    .ser     (slot_ser),
    .ret_vld (ret_vld),
    .tag0    (ret_tag0),
    .tag1    (ret_tag1),
    .flush   (flush_out),
    .ser_go  (ser_go)
  );

  // slot invalidation: retirement, internal flush, redirect by age
  for (genvar s = 0; s < DEPTH; s++) begin : g_kill
    int age;
    always_comb begin
      age     = cq_wrap(s + DEPTH - int'(hd_q), DEPTH);
      kill[s] = flush_out
             || (redir_hit && (age > tag_off))
             || (ret_vld[0] && (ret_tag0 == TW'(s)))
             || (ret_vld[1] && (ret_tag1 == TW'(s)));
    end
  end

  cq_entries #(.DEPTH(DEPTH), .NFIN(NFIN)) u_ent (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc_en),
    .alloc_ser (alloc_ser),
    .alloc_rf  (alloc_rf),
    .kill      (kill),
    .fin_vld   (fin_vld),
    .fin_tag   (fin_tag),
    .fin_exc   (fin_exc),
    .slot_vld  (slot_vld),
    .slot_done (slot_done),
    .slot_exc  (slot_exc),
    .slot_ser  (slot_ser),
    .slot_rf   (slot_rf)
  );

  // pointer and occupancy next state
  always_comb begin
    n_ret  = {1'b0, ret_vld[0]} + {1'b0, ret_vld[1]};
    hd_d   = hd_q;
    tl_d   = tl_q;
    cnt_d  = cnt_q;
    ptr_en = redir_hit || flush_out || (|ret_vld) || (|n_acc);
    if (redir_hit) begin
      tl_d  = TW'(cq_wrap(int'(redir_tag) + 1, DEPTH));
      cnt_d = CW'(tag_off + 1);
    end else if (flush_out) begin
      hd_d  = TW'(cq_wrap(int'(hd_q) + 1, DEPTH));
      tl_d  = hd_d;
      cnt_d = '0;
    end else begin
      hd_d  = TW'(cq_wrap(int'(hd_q) + int'(n_ret), DEPTH));
      tl_d  = TW'(cq_wrap(int'(tl_q) + int'(n_acc), DEPTH));
      cnt_d = cnt_q - CW'(n_ret) + CW'(n_acc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q  <= '0;
      tl_q  <= '0;
      cnt_q <= '0;
    end else if (ptr_en) begin
      hd_q  <= hd_d;
      tl_q  <= tl_d;
      cnt_q <= cnt_d;
    end
  end

  assert_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  assert_full_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH) && (|disp_req)) |-> disp_stall);

  assert_head_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ret_vld[0] |-> (slot_vld[hd_q] && slot_done[hd_q]));

  assert_pair_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_vld[1] |-> (ret_vld[0] && !flush_out));

  assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_out |=> (cnt_q == '0 && slot_vld == '0));

  assert_redir_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redir_hit |=> (hd_q == $past(hd_q)));

  assert_ser_head_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ser_go |-> (slot_vld[hd_q] && !slot_done[hd_q]));

  assert_flush_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_out && (|disp_req)) |-> disp_stall);

endmodule

// File: tb/sim_cmpl_queue.sv
`timescale 1ns/1ps
module sim_cmpl_queue;

  localparam int TW = 4;

  typedef struct {
    int tag;
    bit fl;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic [1:0]    disp_req, disp_ser, disp_rfch;
  logic          disp_stall;
  logic [TW-1:0] disp_tag0, disp_tag1;
  logic [1:0]    fin_vld, fin_exc;
  logic [2*TW-1:0] fin_tag;
  logic          redir_vld;
  logic [TW-1:0] redir_tag;
  logic [1:0]    ret_vld;
  logic [TW-1:0] ret_tag0, ret_tag1;
  logic          flush_out, ser_go;

  int   checks = 0;
  int   errors = 0;
  exp_t sb[$];

  cmpl_queue u0 (
    .clk(clk), .rst_n(rst_n),
    .disp_req(disp_req), .disp_ser(disp_ser), .disp_rfch(disp_rfch),
    .disp_stall(disp_stall), .disp_tag0(disp_tag0), .disp_tag1(disp_tag1),
    .fin_vld(fin_vld), .fin_tag(fin_tag), .fin_exc(fin_exc),
    .redir_vld(redir_vld), .redir_tag(redir_tag),
    .ret_vld(ret_vld), .ret_tag0(ret_tag0), .ret_tag1(ret_tag1),
    .flush_out(flush_out), .ser_go(ser_go)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic expect_ret(input int tag, input bit fl);
    exp_t e;
    e.tag = tag;
    e.fl  = fl;
    sb.push_back(e);
  endtask

  // one cycle of stimulus, applied on the falling edge
  task automatic drive(input logic [1:0] req = 2'b00, input logic [1:0] ser = 2'b00,
                       input logic [1:0] rf = 2'b00, input logic [1:0] fv = 2'b00,
                       input int ft0 = 0, input int ft1 = 0, input logic [1:0] fe = 2'b00,
                       input logic rv = 1'b0, input int rt = 0);
    @(negedge clk);
    disp_req  = req;
    disp_ser  = ser;
    disp_rfch = rf;
    fin_vld   = fv;
    fin_tag   = {TW'(ft1), TW'(ft0)};
    fin_exc   = fe;
    redir_vld = rv;
    redir_tag = TW'(rt);
    #1;
  endtask

  // scoreboard monitor: samples 5 ns before each rising edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #5;
      if (rst_n) begin
        if (ret_vld[1] && !ret_vld[0]) chk("R5 lane1 without lane0", 1, 0);
        if (ret_vld[0]) begin
          if (sb.size() == 0) chk("R4 unexpected retire tag", int'(ret_tag0), -1);
          else begin
            e = sb.pop_front();
            chk("R4 retire order lane0", int'(ret_tag0), e.tag);
            chk("R6 flush with retire", int'(flush_out), int'(e.fl));
          end
        end
        if (ret_vld[1]) begin
          if (sb.size() == 0) chk("R5 unexpected retire tag", int'(ret_tag1), -1);
          else begin
            e = sb.pop_front();
            chk("R5 retire order lane1", int'(ret_tag1), e.tag);
          end
        end
      end
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    disp_req = '0; disp_ser = '0; disp_rfch = '0;
    fin_vld = '0; fin_tag = '0; fin_exc = '0;
    redir_vld = 1'b0; redir_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    drive();
    chk("R9 no retire after reset", int'(ret_vld), 0);
    chk("R9 no flush after reset", int'(flush_out), 0);
    chk("R9 ser_go low after reset", int'(ser_go), 0);

    drive(.req(2'b11));
    chk("R9 first tag0", int'(disp_tag0), 0);
    chk("R2 lane1 tag", int'(disp_tag1), 1);
    chk("R1 accept when empty", int'(disp_stall), 0);

    // R4 younger finished first
    drive(.fv(2'b01), .ft0(1));
    drive(.fv(2'b01), .ft0(0));
    chk("R4 no retire past unfinished head", int'(ret_vld), 0);
    expect_ret(0, 0); expect_ret(1, 0);
    drive();
    chk("R5 dual retire", int'(ret_vld), 3);

    // fill to capacity: tags 2..13 then 0,1
    for (int i = 0; i < 7; i++) begin
      drive(.req(2'b11));
      if (i == 6) begin
        chk("R2 wrap tag0", int'(disp_tag0), 0);
        chk("R2 wrap tag1", int'(disp_tag1), 1);
      end
    end
    drive(.req(2'b01), .fv(2'b01), .ft0(2));
    chk("R1 stall when full", int'(disp_stall), 1);
    expect_ret(2, 0);
    drive(.req(2'b11));
    chk("R1 freed slot not counted same cycle", int'(disp_stall), 1);
    drive(.req(2'b11));
    chk("R1 stall one free two requested", int'(disp_stall), 1);
    drive(.req(2'b01));
    chk("R1 accept one into last slot", int'(disp_stall), 0);
    chk("R2 reused tag", int'(disp_tag0), 2);

    // R6 exception at head, younger finished entry dropped
    drive(.fv(2'b11), .ft0(3), .ft1(4), .fe(2'b01));
    expect_ret(3, 1);
    drive(.req(2'b01));
    chk("R6 exception retires alone", int'(ret_vld), 1);
    chk("R6 flush raised", int'(flush_out), 1);
    chk("R10 dispatch stalls during flush", int'(disp_stall), 1);
    drive(.req(2'b11));
    chk("R6 tail after flush", int'(disp_tag0), 4);
    drive();
    chk("R6 flushed finish state not kept", int'(ret_vld), 0);

    // R6 refetch mark
    drive(.req(2'b11), .rf(2'b01));
    drive(.fv(2'b11), .ft0(4), .ft1(5));
    expect_ret(4, 0); expect_ret(5, 0);
    drive(.fv(2'b11), .ft0(6), .ft1(7));
    chk("R5 pair retire", int'(ret_vld), 3);
    expect_ret(6, 1);
    drive();
    chk("R6 refetch retires alone", int'(ret_vld), 1);
    chk("R6 refetch flush", int'(flush_out), 1);
    drive(.req(2'b11));
    chk("R6 tail after refetch flush", int'(disp_tag0), 7);

    // R7 redirect
    drive(.req(2'b11));
    drive(.req(2'b01), .rv(1'b1), .rt(8));
    chk("R7 dispatch stalls on redirect", int'(disp_stall), 1);
    drive(.req(2'b01));
    chk("R7 tail after redirect", int'(disp_tag0), 9);
    drive(.fv(2'b11), .ft0(10), .ft1(7));
    expect_ret(7, 0);
    drive(.req(2'b01), .fv(2'b01), .ft0(8));
    chk("R3 slot reused after ignored report", int'(disp_tag0), 10);
    expect_ret(8, 0);
    drive(.fv(2'b01), .ft0(9));
    expect_ret(9, 0);
    drive();
    drive();
    chk("R3 stale report ignored", int'(ret_vld), 0);
    drive(.fv(2'b01), .ft0(10));
    expect_ret(10, 0);
    drive();
    drive(.req(2'b01), .rv(1'b1), .rt(3));
    chk("R7 invalid redirect ignored stall", int'(disp_stall), 0);
    chk("R7 invalid redirect ignored tag", int'(disp_tag0), 11);
    drive(.req(2'b01));
    chk("R7 tail unchanged by invalid redirect", int'(disp_tag0), 12);

    // R8 serialization
    drive(.req(2'b01), .ser(2'b01));
    chk("R8 serialized tag", int'(disp_tag0), 13);
    drive();
    chk("R8 not at head", int'(ser_go), 0);
    drive(.fv(2'b11), .ft0(11), .ft1(12));
    expect_ret(11, 0); expect_ret(12, 0);
    drive();
    drive();
    chk("R8 go at head", int'(ser_go), 1);
    chk("R8 no retire while unfinished", int'(ret_vld), 0);
    drive(.fv(2'b01), .ft0(13));
    expect_ret(13, 0);
    drive();
    chk("R8 go drops once finished", int'(ser_go), 0);
    drive();
    drive();
    chk("R4 all expected retirements seen", sb.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule